// File: doc/BRIEF.md
# Serial Sampling Converter Port Model

This block models the digital side of a serial sampling converter that has a three-wire port. The pins are a conversion-start input, a serial clock input and a serial data output. A rising edge on the start input captures a parallel sample word, which stands in for the converter core. The captured word is then shifted out MSB first, in a 16-clock frame timed by the serial clock. While a frame is in progress, further start edges are locked out, and a one-cycle status pulse reports each start edge that the lockout ignored. A separate request input puts the port into a low-power sleep state. Any serial clock rising edge ends that state.

All port pins are sampled as levels in the block's own clock domain, and their edges are detected there. The serial clock must therefore run well below the system clock, with each high and low phase lasting at least one system clock. The sample input is a plain level. It is read only in the cycle in which a start edge is accepted, so it has no valid/ready handshake and no back-pressure. The serial output has no back-pressure either: the receiver takes each bit on a serial clock rising edge. The sample width is a parameter, either 12 or 14 bits.

Top module: `sconv_port`

## Requirements
- R1: After reset, sdo_o, busy_o, asleep_o and conv_ignored_o are all 0.
- R2: A rising edge on conv_i seen while busy_o and asleep_o are both low starts a frame: busy_o is 1 from the next cycle, and sample_i is captured in the cycle the edge is detected.
- R3: A conv_i rising edge seen while busy_o is high starts nothing and leaves the frame in progress unchanged. In that case conv_ignored_o is 1 for exactly the next cycle. conv_ignored_o is never high otherwise.
- R4: A frame ends at the 16th sck_i rising edge after its start, and busy_o is 0 from the next cycle. This holds even when a conv_i rising edge arrives in the same cycle as that 16th edge: that edge is ignored under R3. The next start edge after the frame ends is accepted.
- R5: The frame is, MSB first: two 0 bits, then the sample MSB first, then 14-RES_BITS trailing 0 bits. The k-th bit (k = 1..16) is on sdo_o when the k-th sck_i rising edge is detected. The first bit is presented from the start of the frame. After that, sdo_o advances by one bit only on an sck_i falling edge that follows a rising edge, so a falling edge before the first rising edge shifts nothing.
- R6: sdo_o is 0 whenever busy_o is 0.
- R7: When sleep_req_i is 1, the port is idle, the port is awake and no conv_i rising edge is seen, asleep_o becomes 1 in the next cycle. While busy_o is 1, sleep_req_i has no effect.
- R8: While asleep_o is 1, a conv_i rising edge neither starts a frame nor pulses conv_ignored_o. The first sck_i rising edge clears asleep_o in the next cycle.
- R9: The parameter RES_BITS selects a 12- or 14-bit sample, and the frame length stays 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_i | input | 1 | Conversion start; rising edge starts a frame |
| sck_i | input | 1 | Serial clock level |
| sleep_req_i | input | 1 | Request to enter sleep while idle |
| sample_i | input | RES_BITS | Parallel sample from the converter core |
| sdo_o | output | 1 | Serial data out, MSB first |
| busy_o | output | 1 | Frame in progress (lockout active) |
| asleep_o | output | 1 | Sleep state |
| conv_ignored_o | output | 1 | One-cycle pulse for a locked-out start edge |

## Verification
The hardest situation to reach is a start edge that lands in the same system cycle as the 16th serial clock rising edge. At that boundary the lockout must still win, and the frame must still close. The bench reaches it by driving sck_i high and conv_i high at the same instant after fifteen full serial clock pulses. A second hard case is a serial clock that is already high when a frame starts, so that its first falling edge must not shift. The bench produces it by raising sck_i before the start pulse. A behavioural reference model, built on a bit queue, follows every cycle, and a receiver in the bench reassembles each word from the bits taken on rising edges.

// File: rtl/sconv_pkg.sv
package sconv_pkg;
  localparam int FRAME_BITS = 16;
  localparam int LEAD_ZEROS = 2;
  localparam int N_EDGE_IN  = 2;
  localparam int IDX_CONV   = 0;
  localparam int IDX_SCK    = 1;
endpackage

// File: rtl/sconv_edge_det.sv
module sconv_edge_det #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_edge
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= level_i[g];
    end
    assign rise_o[g] = level_i[g] & ~prev_q[g];
    assign fall_o[g] = ~level_i[g] & prev_q[g];
  end
endmodule

// File: rtl/sconv_frame_ctrl.sv
module sconv_frame_ctrl #(
  parameter int FRAME_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_rise_i,
  input  logic sck_rise_i,
  input  logic sleep_req_i,
  output logic start_o,
  output logic busy_o,
  output logic asleep_o,
  output logic ignored_o
);
  localparam int CW = $clog2(FRAME_BITS);

  logic          busy_q, asleep_q, ign_q;
  logic [CW-1:0] rise_cnt_q;
  logic          last_rise;

  assign start_o   = conv_rise_i & ~busy_q & ~asleep_q;
  assign last_rise = busy_q & sck_rise_i & (rise_cnt_q == CW'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      rise_cnt_q <= '0;
      ign_q      <= 1'b0;
    end else begin
      ign_q <= conv_rise_i & busy_q;
      if (start_o) begin
        busy_q     <= 1'b1;
        rise_cnt_q <= '0;
      end else if (busy_q && sck_rise_i) begin
        if (last_rise) begin
          busy_q     <= 1'b0;
          rise_cnt_q <= '0;
        end else begin
          rise_cnt_q <= rise_cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                                  asleep_q <= 1'b0;
    else if (asleep_q && sck_rise_i)                             asleep_q <= 1'b0;
    else if (!asleep_q && !busy_q && sleep_req_i && !conv_rise_i) asleep_q <= 1'b1;
  end

  assign busy_o    = busy_q;
  assign asleep_o  = asleep_q;
  assign ignored_o = ign_q;

  assert_lockout_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && conv_rise_i |=> ign_q);
  assert_pulse_only_on_lockout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ign_q |-> $past(busy_q && conv_rise_i));
  assert_frame_ends_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(sck_rise_i));
  assert_sleep_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep_q) |-> $past(!busy_q && sleep_req_i));
  assert_wake_on_sck_R8: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_q && sck_rise_i |=> !asleep_q);
  assert_no_start_asleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(!asleep_q));
endmodule

// File: rtl/sconv_frame_shifter.sv
module sconv_frame_shifter #(
  parameter int RES_BITS   = 12,
  parameter int FRAME_BITS = 16,
  parameter int LEAD_ZEROS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                busy_i,
  input  logic                sck_rise_i,
  input  logic                sck_fall_i,
  input  logic [RES_BITS-1:0] sample_i,
  output logic                sdo_o
);
  localparam int TRAIL = FRAME_BITS - LEAD_ZEROS - RES_BITS;

  logic [FRAME_BITS-1:0] ext_w, frame_w, shreg_q;
  logic                  armed_q;

  assign ext_w   = {{(FRAME_BITS - RES_BITS){1'b0}}, sample_i};
  assign frame_w = ext_w << TRAIL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q <= '0;
      armed_q <= 1'b0;
    end else if (start_i) begin
      shreg_q <= frame_w;
      armed_q <= 1'b0;
    end else if (busy_i) begin
      if (sck_rise_i) begin
        armed_q <= 1'b1;
      end else if (sck_fall_i && armed_q) begin
        shreg_q <= shreg_q << 1;
        armed_q <= 1'b0;
      end
    end
  end

  assign sdo_o = busy_i & shreg_q[FRAME_BITS-1];

  assert_change_only_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && $past(busy_i) && !$past(sck_fall_i) |-> $stable(sdo_o));
endmodule

// File: rtl/sconv_port.sv
module sconv_port #(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_i,
  input  logic                sck_i,
  input  logic                sleep_req_i,
  input  logic [RES_BITS-1:0] sample_i,
  output logic                sdo_o,
  output logic                busy_o,
  output logic                asleep_o,
  output logic                conv_ignored_o
);
  import sconv_pkg::*;

  logic [N_EDGE_IN-1:0] lvl, rise, fall;
  logic                 start;

  assign lvl[IDX_CONV] = conv_i;
  assign lvl[IDX_SCK]  = sck_i;

  sconv_edge_det #(.WIDTH(N_EDGE_IN)) u_edges (
    .clk(clk), .rst_n(rst_n), .level_i(lvl), .rise_o(rise), .fall_o(fall)
  );

  sconv_frame_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .conv_rise_i(rise[IDX_CONV]), .sck_rise_i(rise[IDX_SCK]),
    .sleep_req_i(sleep_req_i),
    .start_o(start), .busy_o(busy_o), .asleep_o(asleep_o),
    .ignored_o(conv_ignored_o)
  );

  sconv_frame_shifter #(
    .RES_BITS(RES_BITS), .FRAME_BITS(FRAME_BITS), .LEAD_ZEROS(LEAD_ZEROS)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_i(busy_o),
    .sck_rise_i(rise[IDX_SCK]), .sck_fall_i(fall[IDX_SCK]),
    .sample_i(sample_i), .sdo_o(sdo_o)
  );

  assert_conv_fall_unused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fall[IDX_CONV] && !busy_o |=> !busy_o);
endmodule

// File: tb/sconv_port_test.sv
module sconv_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int RES = 12;
  localparam int TRAIL = 16 - 2 - RES;

  logic clk = 0, rst_n = 0, conv = 0, sck = 0, sleep_req = 0;
  logic [RES-1:0] sample = '0;
  logic sdo, busy, asleep, ign;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sconv_port #(.RES_BITS(RES)) uut (
    .clk(clk), .rst_n(rst_n), .conv_i(conv), .sck_i(sck), .sleep_req_i(sleep_req),
    .sample_i(sample), .sdo_o(sdo), .busy_o(busy), .asleep_o(asleep),
    .conv_ignored_o(ign)
  );

  // reference model
  bit m_busy, m_asleep, m_ign, m_armed, pc, ps;
  int m_rises;
  bit m_q[$];
  logic [15:0] rx_word;
  int rx_n, ign_seen;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_asleep = 0; m_ign = 0; m_armed = 0; pc = 0; ps = 0;
      m_rises = 0; m_q.delete(); ign_seen = 0;
    end else begin
      bit cr, sr, sf, ob, oa;
      logic [15:0] fr;
      cr = conv && !pc; sr = sck && !ps; sf = !sck && ps;
      ob = m_busy; oa = m_asleep;
      if (ign) ign_seen++;
      if (ob && sr) begin rx_word = {rx_word[14:0], sdo}; rx_n++; end
      m_ign = cr && ob;
      if (cr && !ob && !oa) begin
        fr = 16'(sample) << TRAIL;
        m_q.delete();
        for (int i = 15; i >= 0; i--) m_q.push_back(fr[i]);
        m_busy = 1; m_rises = 0; m_armed = 0;
      end else if (ob) begin
        if (sr) begin
          m_rises++; m_armed = 1;
          if (m_rises == 16) m_busy = 0;
        end else if (sf && m_armed) begin
          void'(m_q.pop_front()); m_armed = 0;
        end
      end
      if (oa && sr) m_asleep = 0;
      else if (!oa && !ob && sleep_req && !cr) m_asleep = 1;
      pc = conv; ps = sck;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit esdo;
      esdo = (m_busy && m_q.size() > 0) ? m_q[0] : 1'b0;
      chk(sdo == esdo, "R5/R6 sdo", sdo, esdo);
      chk(busy == m_busy, "R2/R4 busy", busy, m_busy);
      chk(asleep == m_asleep, "R7/R8 asleep", asleep, m_asleep);
      chk(ign == m_ign, "R3 conv_ignored", ign, m_ign);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic sck_pulse(int hi, int lo);
    sck = 1; tick(hi); sck = 0; tick(lo);
  endtask

  task automatic conv_pulse();
    conv = 1; tick(1); conv = 0; tick(1);
  endtask

  // runs a full frame; inject >= 0 places a locked-out start after that many pulses
  task automatic run_frame(logic [RES-1:0] s, int hi, int lo, int inject);
    logic [15:0] expw;
    int ig0;
    expw = 16'(s) << TRAIL;
    sample = s; rx_n = 0; rx_word = '0; ig0 = ign_seen;
    conv = 1; tick(1);
    chk(busy == 1, "R2 busy after start", busy, 1);
    conv = 0; sample = ~s; tick(1);
    for (int k = 0; k < 16; k++) begin
      if (k == inject) conv_pulse();
      sck_pulse(hi, lo);
    end
    tick(2);
    chk(rx_n == 16, "R4 rise count", rx_n, 16);
    chk(rx_word == expw, "R5/R9 word", rx_word, expw);
    chk(busy == 0, "R4 busy after frame", busy, 0);
    chk(sdo == 0, "R6 sdo idle", sdo, 0);
    if (inject >= 0) chk(ign_seen == ig0 + 1, "R3 ignored pulses", ign_seen - ig0, 1);
  endtask

  initial begin
    tick(3);
    chk(sdo == 0 && busy == 0 && asleep == 0 && ign == 0, "R1 reset state",
        {sdo, busy, asleep, ign}, 0);
    rst_n = 1; tick(2);

    run_frame(12'hABC, 1, 1, -1);
    run_frame(12'hFFF, 2, 3, -1);
    run_frame(12'h555, 1, 2, 5);
    run_frame(12'h800, 3, 1, 0);

    // start edge coincident with the 16th rising edge (R4, R3)
    begin
      int ig0;
      sample = 12'h3C3; conv_pulse();
      for (int k = 0; k < 15; k++) sck_pulse(1, 1);
      ig0 = ign_seen;
      sck = 1; conv = 1; tick(1);
      sck = 0; conv = 0; tick(2);
      chk(busy == 0, "R4 frame closes at coincident edge", busy, 0);
      chk(ign_seen == ig0 + 1, "R3 coincident start ignored", ign_seen - ig0, 1);
    end
    run_frame(12'h123, 1, 1, -1);

    // serial clock high at frame start: first fall must not shift (R5)
    sck = 1; tick(2);
    begin
      logic [15:0] expw;
      sample = 12'hC35; expw = 16'(sample) << TRAIL;
      rx_n = 0; rx_word = '0;
      conv_pulse(); sck = 0; tick(2);
      for (int k = 0; k < 16; k++) sck_pulse(1, 1);
      tick(2);
      chk(rx_word == expw, "R5 word with early fall", rx_word, expw);
    end

    // sleep (R7, R8)
    sample = 12'h0F0; conv_pulse();
    sleep_req = 1; tick(3);
    chk(asleep == 0, "R7 no sleep while busy", asleep, 0);
    sleep_req = 0;
    for (int k = 0; k < 16; k++) sck_pulse(1, 1);
    tick(1);
    sleep_req = 1; tick(2);
    chk(asleep == 1, "R7 sleep when idle", asleep, 1);
    sleep_req = 0;
    begin
      int ig0;
      ig0 = ign_seen;
      conv_pulse(); tick(1);
      chk(busy == 0, "R8 start ignored asleep", busy, 0);
      chk(ign_seen == ig0, "R8 no ignored pulse asleep", ign_seen - ig0, 0);
    end
    sck = 1; tick(1);
    chk(asleep == 0, "R8 wake on sck rise", asleep, 0);
    sck = 0; tick(2);
    run_frame(12'h000, 1, 1, -1);
    run_frame(12'hA5A, 2, 2, 9);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule